// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block sits between a chip's pins and its core logic and holds one scan cell for every input pin and every output pin. Each cell has a shift stage, which is part of a serial path from `tdi` to `tdo`, and an update latch that can stand in for the pin or the core signal. An external instruction decoder picks the operating mode and an external test-port state machine supplies the capture, shift and update strobes. All state is clocked on `tck` and cleared by the active-low test reset `trstN`.

In normal mode the cells pass data straight through, so the core sees the pins and the pins see the core. The chain can still sample live values and can be preloaded. In test mode the update latches drive both the core inputs and the output pins. When test data is captured, input cells take the inverse of what they are feeding the core, while output cells take the true core output. In clamp or high-impedance mode the output drivers are switched off and their data comes from the latches, which lets a safe pattern be preloaded first.

Top module: `bscan_chain`

## Requirements
- R1: While `trstN` is low, every shift stage and every update latch is cleared to 0, so entering test mode right after reset drives 0 on every core input and every output pin.
- R2: In normal mode (`mode` = 2'b00) the block is transparent: `coreIn` equals `pinIn`, `pinOut` equals `coreOut`, and `pinOutEn` equals `coreOutEn`.
- R3: The chain holds NUM_IN + NUM_OUT stages. Shift stage i (for i < NUM_IN) belongs to input pin i, and stage NUM_IN+j belongs to output pin j. In any mode other than test, a `captureDr` edge loads `pinIn` into the input stages and `coreOut` into the output stages, without inversion.
- R4: On a `shiftDr` edge, stage 0 takes `tdi` and every other stage takes the stage below it. `tdo` always shows the highest stage, so a captured vector leaves MSB first, and a bit entered at `tdi` reaches `tdo` after NUM_IN + NUM_OUT shifts.
- R5: On an `updateDr` edge the update latches copy the shift stages in every mode. In test mode the copied values reach `coreIn` and `pinOut` right after that edge.
- R6: In test mode (`mode` = 2'b01) a `captureDr` edge loads each input stage with the complement of the value that cell is driving into the core, and loads each output stage with the true `coreOut` bit.
- R7: In test mode `pinOutEn` is all ones, and `coreIn` and `pinOut` come from the update latches.
- R8: In clamp mode (`mode` = 2'b10) and in high-impedance mode (2'b11), `pinOutEn` is all zeros, `pinOut` comes from the update latches, and `coreIn` follows `pinIn`.
- R9: The update latches change only on an `updateDr` edge. Capture and shift edges leave them unchanged.
- R10: On a clock edge with no strobe, the shift stages keep their contents. If strobes overlap, capture wins over shift, and shift wins over update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous active-low test-logic reset |
| mode | input | 2 | 00 normal, 01 test, 10 clamp, 11 high-impedance |
| captureDr | input | 1 | Capture strobe |
| shiftDr | input | 1 | Shift strobe |
| updateDr | input | 1 | Update strobe |
| tdi | input | 1 | Serial scan data in |
| tdo | output | 1 | Serial scan data out (highest stage) |
| pinIn | input | NUM_IN | Values arriving from the input pins |
| coreIn | output | NUM_IN | Values delivered to the core logic |
| coreOut | input | NUM_OUT | Output data produced by the core |
| coreOutEn | input | NUM_OUT | Output enables produced by the core |
| pinOut | output | NUM_OUT | Data sent to the output drivers |
| pinOutEn | output | NUM_OUT | Enables sent to the output drivers |

## Verification
The assertions assume that the state machine upstream raises at most one of `captureDr`, `shiftDr` and `updateDr` in any cycle, and that `mode` changes only while no strobe is active. One property checks the first assumption directly. The stimulus changes inputs only on falling edges and raises one strobe at a time, so the priority order is never exercised. The bench sweeps every preload value of a small chain (three inputs, two outputs) and every combination of normal-mode inputs, and it computes the expected vectors by bit arithmetic.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_TEST   = 2'b01,
    MODE_CLAMP  = 2'b10,
    MODE_HIGHZ  = 2'b11
  } bsMode_t;

  // strobes and mode flags passed from control to datapath
  typedef struct packed {
    logic cap;
    logic shift;
    logic upd;
    logic testMode;
    logic clampMode;
  } bsStrobe_t;

endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic      [1:0] mode,
  input  logic            captureDr,
  input  logic            shiftDr,
  input  logic            updateDr,
  output bsStrobe_t       stb
);

  bsMode_t modeE;

  always_comb begin
    modeE         = bsMode_t'(mode);
    // capture has priority over shift, shift over update
    stb.cap       = captureDr;
    stb.shift     = shiftDr & ~captureDr;
    stb.upd       = updateDr & ~captureDr & ~shiftDr;
    stb.testMode  = (modeE == MODE_TEST);
    stb.clampMode = (modeE == MODE_CLAMP) || (modeE == MODE_HIGHZ);
  end

endmodule

// File: rtl/bscan_path.sv
module bscan_path
  import bscan_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8,
  localparam int LEN    = NUM_IN + NUM_OUT
) (
  input  logic               tck,
  input  logic               trstN,
  input  bsStrobe_t          stb,
  input  logic               tdi,
  output logic               tdo,
  input  logic [NUM_IN-1:0]  pinIn,
  output logic [NUM_IN-1:0]  coreIn,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic [NUM_OUT-1:0] coreOutEn,
  output logic [NUM_OUT-1:0] pinOut,
  output logic [NUM_OUT-1:0] pinOutEn,
  output logic [LEN-1:0]     shiftQ,
  output logic [LEN-1:0]     latchQ
);

  logic [LEN-1:0] capVal;

  // input cells: stage index equals pin index
  for (genvar i = 0; i < NUM_IN; i++) begin : g_inCell
    assign coreIn[i] = stb.testMode ? latchQ[i] : pinIn[i];
    // test capture records the inverse of the value fed to the core
    assign capVal[i] = stb.testMode ? ~latchQ[i] : pinIn[i];
  end

  // output cells follow the input cells towards tdo
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_outCell
    localparam int IDX = NUM_IN + j;
    assign capVal[IDX]  = coreOut[j];
    assign pinOut[j]    = (stb.testMode || stb.clampMode) ? latchQ[IDX] : coreOut[j];
    assign pinOutEn[j]  = stb.testMode ? 1'b1 : (stb.clampMode ? 1'b0 : coreOutEn[j]);
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      shiftQ <= '0;
    end else if (stb.cap) begin
      shiftQ <= capVal;
    end else if (stb.shift) begin
      shiftQ <= {shiftQ[LEN-2:0], tdi};
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      latchQ <= '0;
    end else if (stb.upd) begin
      latchQ <= shiftQ;
    end
  end

  assign tdo = shiftQ[LEN-1];

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic [1:0]         mode,
  input  logic               captureDr,
  input  logic               shiftDr,
  input  logic               updateDr,
  input  logic               tdi,
  output logic               tdo,
  input  logic [NUM_IN-1:0]  pinIn,
  output logic [NUM_IN-1:0]  coreIn,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic [NUM_OUT-1:0] coreOutEn,
  output logic [NUM_OUT-1:0] pinOut,
  output logic [NUM_OUT-1:0] pinOutEn
);

  localparam int LEN = NUM_IN + NUM_OUT;

  bsStrobe_t      stb;
  logic [LEN-1:0] shiftQ;
  logic [LEN-1:0] latchQ;

  bscan_ctrl u_ctrl (
    .mode      (mode),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .stb       (stb)
  );

  bscan_path #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_path (
    .tck       (tck),
    .trstN     (trstN),
    .stb       (stb),
    .tdi       (tdi),
    .tdo       (tdo),
    .pinIn     (pinIn),
    .coreIn    (coreIn),
    .coreOut   (coreOut),
    .coreOutEn (coreOutEn),
    .pinOut    (pinOut),
    .pinOutEn  (pinOutEn),
    .shiftQ    (shiftQ),
    .latchQ    (latchQ)
  );

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8,
  localparam int LEN    = NUM_IN + NUM_OUT
) (
  input logic               tck,
  input logic               trstN,
  input logic [1:0]         mode,
  input logic               captureDr,
  input logic               shiftDr,
  input logic               updateDr,
  input logic               tdi,
  input logic [NUM_IN-1:0]  pinIn,
  input logic [NUM_IN-1:0]  coreIn,
  input logic [NUM_OUT-1:0] coreOut,
  input logic [NUM_OUT-1:0] coreOutEn,
  input logic [NUM_OUT-1:0] pinOut,
  input logic [NUM_OUT-1:0] pinOutEn,
  input logic [LEN-1:0]     shiftQ,
  input logic [LEN-1:0]     latchQ
);

  // R10 (input assumption: strobes never overlap)
  strobe_excl_chk: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({captureDr, shiftDr, updateDr}));

  // R2
  normal_pass_chk: assert property (@(posedge tck) disable iff (!trstN)
    (mode == 2'b00) |-> (coreIn == pinIn && pinOut == coreOut && pinOutEn == coreOutEn));

  // R7
  test_drive_chk: assert property (@(posedge tck) disable iff (!trstN)
    (mode == 2'b01) |-> (&pinOutEn && coreIn == latchQ[NUM_IN-1:0]
                         && pinOut == latchQ[LEN-1:NUM_IN]));

  // R8
  clamp_off_chk: assert property (@(posedge tck) disable iff (!trstN)
    mode[1] |-> (pinOutEn == '0 && pinOut == latchQ[LEN-1:NUM_IN] && coreIn == pinIn));

  // R9
  latch_hold_chk: assert property (@(posedge tck) disable iff (!trstN)
    !updateDr |=> $stable(latchQ));

  // R5
  latch_load_chk: assert property (@(posedge tck) disable iff (!trstN)
    (updateDr && !captureDr && !shiftDr) |=> (latchQ == $past(shiftQ)));

  // R4
  shift_entry_chk: assert property (@(posedge tck) disable iff (!trstN)
    (shiftDr && !captureDr) |=> (shiftQ[0] == $past(tdi)));

  // R10
  idle_hold_chk: assert property (@(posedge tck) disable iff (!trstN)
    (!captureDr && !shiftDr) |=> $stable(shiftQ));

  // R6
  test_capture_chk: assert property (@(posedge tck) disable iff (!trstN)
    (captureDr && mode == 2'b01) |=>
      (shiftQ[NUM_IN-1:0] == ~$past(coreIn) && shiftQ[LEN-1:NUM_IN] == $past(coreOut)));

  // R3
  sample_capture_chk: assert property (@(posedge tck) disable iff (!trstN)
    (captureDr && mode != 2'b01) |=> (shiftQ == $past({coreOut, pinIn})));

endmodule

bind bscan_chain bscan_chain_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
  .tck       (tck),
  .trstN     (trstN),
  .mode      (mode),
  .captureDr (captureDr),
  .shiftDr   (shiftDr),
  .updateDr  (updateDr),
  .tdi       (tdi),
  .pinIn     (pinIn),
  .coreIn    (coreIn),
  .coreOut   (coreOut),
  .coreOutEn (coreOutEn),
  .pinOut    (pinOut),
  .pinOutEn  (pinOutEn),
  .shiftQ    (shiftQ),
  .latchQ    (latchQ)
);

// File: tb/bscan_chain_tb.sv
module bscan_chain_tb;

  localparam int NI  = 3;
  localparam int NO  = 2;
  localparam int LEN = NI + NO;

  logic          tck = 1'b0;
  logic          trstN = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic          tdo;
  logic [NI-1:0] pinIn = '0, coreIn;
  logic [NO-1:0] coreOut = '0, coreOutEn = '0, pinOut, pinOutEn;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 tck = ~tck;

  bscan_chain #(.NUM_IN(NI), .NUM_OUT(NO)) u_dut (
    .tck(tck), .trstN(trstN), .mode(mode), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .tdo(tdo),
    .pinIn(pinIn), .coreIn(coreIn), .coreOut(coreOut), .coreOutEn(coreOutEn),
    .pinOut(pinOut), .pinOutEn(pinOutEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // shift LEN bits: inV leaves MSB-first into tdi, outV collects tdo MSB-first
  task automatic shiftVec(input logic [LEN-1:0] inV, output logic [LEN-1:0] outV);
    for (int k = 0; k < LEN; k++) begin
      @(negedge tck);
      shiftDr = 1'b1;
      tdi     = inV[LEN-1-k];
      #1 outV[LEN-1-k] = tdo;
    end
    @(negedge tck);
    shiftDr = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge tck);
    if (which == 0) captureDr = 1'b1; else updateDr = 1'b1;
    @(negedge tck);
    captureDr = 1'b0;
    updateDr  = 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [LEN-1:0] got, dummy;
    repeat (3) @(negedge tck);
    mode = 2'b01;
    #1;
    // R1: cleared latches drive zeros in test mode during and after reset
    check("R1 coreIn reset", 32'(coreIn), 0);
    check("R1 pinOut reset", 32'(pinOut), 0);
    check("R1 tdo reset", 32'(tdo), 0);
    @(negedge tck);
    trstN = 1'b1;
    @(negedge tck);
    check("R1 coreIn after reset", 32'(coreIn), 0);
    check("R7 enable after reset", 32'(pinOutEn), 32'((1 << NO) - 1));
    mode = 2'b00;

    // R2: exhaustive transparency sweep
    for (int p = 0; p < (1 << NI); p++)
      for (int c = 0; c < (1 << NO); c++)
        for (int e = 0; e < (1 << NO); e++) begin
          @(negedge tck);
          pinIn = NI'(p); coreOut = NO'(c); coreOutEn = NO'(e);
          #1;
          check("R2 coreIn", 32'(coreIn), 32'(p));
          check("R2 pinOut", 32'(pinOut), 32'(c));
          check("R2 pinOutEn", 32'(pinOutEn), 32'(e));
        end

    // R3: sample capture in normal and clamp modes, shifted out MSB-first
    for (int v = 0; v < (1 << LEN); v += 3) begin
      @(negedge tck);
      mode = (v % 2 == 0) ? 2'b00 : 2'b10;
      pinIn = NI'(v); coreOut = NO'(v >> NI);
      pulse(0);
      shiftVec('0, got);
      check("R3 sample vector", 32'(got), 32'(v));
    end

    // R4: shift-through latency of LEN
    mode = 2'b00;
    for (int v = 0; v < (1 << LEN); v += 5) begin
      shiftVec(LEN'(v), dummy);
      shiftVec('0, got);
      check("R4 shift through", 32'(got), 32'(v));
    end

    // R10: idle cycles keep the stages
    shiftVec(LEN'(5'b10110), dummy);
    repeat (6) @(negedge tck);
    shiftVec('0, got);
    check("R10 idle hold", 32'(got), 32'(5'b10110));

    // R5 R6 R7 R9 R8: full preload sweep
    for (int v = 0; v < (1 << LEN); v++) begin
      int c;
      c = (v * 3 + 1) % (1 << NO);
      @(negedge tck);
      mode = 2'b00;
      shiftVec(LEN'(v), dummy);
      pulse(1);
      @(negedge tck);
      mode = 2'b01;
      coreOut = NO'(c);
      pinIn = ~NI'(v);
      #1;
      check("R5 coreIn from latch", 32'(coreIn), 32'(v % (1 << NI)));
      check("R5 pinOut from latch", 32'(pinOut), 32'(v >> NI));
      check("R7 enables on", 32'(pinOutEn), 32'((1 << NO) - 1));
      pulse(0);
      shiftVec(~LEN'(v), got);
      check("R6 test capture", 32'(got),
            32'((c << NI) | ((~v) & ((1 << NI) - 1))));
      // R9: capture and shift left the latches alone
      check("R9 latch hold", 32'({pinOut, coreIn}), 32'(v));
      @(negedge tck);
      mode = (v % 2 == 0) ? 2'b10 : 2'b11;
      #1;
      check("R8 clamp enables off", 32'(pinOutEn), 0);
      check("R8 clamp pinOut", 32'(pinOut), 32'(v >> NI));
      check("R8 clamp coreIn", 32'(coreIn), 32'(pinIn));
    end

    // R5: update in test mode takes effect right after the edge
    @(negedge tck);
    mode = 2'b01;
    shiftVec(LEN'(5'b01101), dummy);
    @(negedge tck);
    updateDr = 1'b1;
    @(negedge tck);
    updateDr = 1'b0;
    check("R5 immediate update", 32'({pinOut, coreIn}), 32'(5'b01101));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule